// File: doc/BRIEF.md
# SDRAM Bank-State Command Legality Checker

This block is a passive monitor on an SDRAM command bus. On every rising clock edge it decodes the chip-select and the three command strobes together with the bank address and the auto-precharge/all-banks address bit. It then judges whether the command is allowed in the current state of the bank it addresses, or of all banks for the commands that act chip-wide. It keeps a small state machine per bank: idle, row open, read burst, write burst, write recovery and auto-refresh. Counters sized in clock cycles time the row-to-column delay, the minimum row-open time, the burst length, the write recovery time and the refresh cycle time.

A legal command advances the bank state machines. An illegal command is flagged with a one-cycle pulse and a three-bit reason code, and leaves every bank as it was. This lets the monitor keep tracking the bus after a violation, using the state the memory itself would have kept. All outputs are registered. The block sits beside a memory controller in simulation or in silicon as a protocol watchdog. It drives nothing onto the bus.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With `cs_n` high the command is deselect. With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as follows: 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge, 001 auto-refresh, 000 mode set. Deselect and no-op are never flagged, in any state.
- R2: `illegal_o`, `err_code_o` and `bank_state_o` show the effect of the command sampled at the previous rising edge. The error codes are: 0 none, 1 activate to a bank that is not idle, 2 read/write to an idle bank, 3 read/write too early after activate, 4 precharge too early after activate, 5 target busy (recovering or refreshing), 6 all banks must be idle. Bank i state sits at `bank_state_o[3i+2:3i]`, coded 0 idle, 1 active, 2 reading, 3 writing, 4 write recovering, 5 refreshing.
- R3: Activate is legal only to an idle bank and moves it to active. Otherwise it is flagged with code 1, or code 5 if the bank is busy.
- R4: Read or write to an idle bank gives code 2. When issued fewer than T_RCD cycles after that bank's activate, it gives code 3.
- R5: Precharge with `a10` low closes the addressed bank, and with `a10` high closes all banks. It gives code 4 if any bank it would close was activated fewer than T_RAS cycles earlier.
- R6: A read started at edge k keeps the bank reading for commands at edges k+1 to k+BURST_LEN-1. From edge k+BURST_LEN the bank is active, or idle if `a10` was high with the read.
- R7: A write started at edge k keeps the bank writing for BURST_LEN cycles, then recovering for T_WR cycles, then active (or idle if `a10` was high). Every command except deselect and no-op is flagged with code 5 while its target bank is recovering or refreshing. The chip-wide commands (burst stop, precharge-all, auto-refresh, mode set) are flagged when any bank is busy.
- R8: Auto-refresh and mode set need all banks idle, else code 6. A legal auto-refresh puts every bank in refreshing for T_RC cycles, after which they are idle.
- R9: Burst stop ends a read burst (the bank becomes active) and ends a write burst early (the bank enters write recovery).
- R10: A flagged command changes no bank state.
- R11: While `rst_n` is low all banks read idle and `illegal_o` and `err_code_o` are 0. Reset is asserted asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low selects |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks option bit |
| bank_state_o | output | 3*NUM_BANKS | Per-bank state, 3 bits per bank |
| illegal_o | output | 1 | One-cycle pulse for a flagged command |
| err_code_o | output | 3 | Reason for the flag, 0 when legal |

## Verification
The bench goes after the exact cycle on which each timer opens. It checks reads at two and at three cycles after activate, and precharge at four and at five cycles. A counter off by one would flag the legal command or pass the early one. It crosses the burst-to-recovery-to-idle hand-off with auto-precharge, and the end of refresh. A state machine that left a timed state one cycle late or early would give the wrong state vector or a spurious code 5. It issues activate to a writing bank and read to a recovering bank to pin the priority between codes 1 and 5. It follows every flagged command with a state check, so a design that let an illegal command move a bank would show a changed state vector.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

  localparam int ST_W  = 3;
  localparam int ERR_W = 3;

  typedef enum logic [3:0] {
    OP_DESEL = 4'd0,
    OP_NOP   = 4'd1,
    OP_BST   = 4'd2,
    OP_READ  = 4'd3,
    OP_WRITE = 4'd4,
    OP_ACT   = 4'd5,
    OP_PRE   = 4'd6,
    OP_REF   = 4'd7,
    OP_MRS   = 4'd8
  } op_e;

  typedef enum logic [ST_W-1:0] {
    BS_IDLE    = 3'd0,
    BS_ACTIVE  = 3'd1,
    BS_READ    = 3'd2,
    BS_WRITE   = 3'd3,
    BS_WRECOV  = 3'd4,
    BS_REFRESH = 3'd5
  } bank_st_e;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE      = 3'd0,
    ERR_ROW_OPEN  = 3'd1,
    ERR_NO_ROW    = 3'd2,
    ERR_RCD       = 3'd3,
    ERR_RAS       = 3'd4,
    ERR_BUSY      = 3'd5,
    ERR_NEED_IDLE = 3'd6
  } err_e;

endpackage

// File: rtl/sdg_rst_sync.sv
module sdg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/sdg_cmd_decode.sv
module sdg_cmd_decode
  import sdg_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output op_e  op_o
);

  always_comb begin
    op_o = OP_DESEL;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  op_o = OP_NOP;
        3'b110:  op_o = OP_BST;
        3'b101:  op_o = OP_READ;
        3'b100:  op_o = OP_WRITE;
        3'b011:  op_o = OP_ACT;
        3'b010:  op_o = OP_PRE;
        3'b001:  op_o = OP_REF;
        default: op_o = OP_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdg_bank_fsm.sv
module sdg_bank_fsm
  import sdg_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_WR      = 2,
  parameter int T_RC      = 6,
  parameter int BURST_LEN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     act_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     pre_i,
  input  logic     bst_i,
  input  logic     ref_i,
  input  logic     a10_i,
  output bank_st_e st_o,
  output logic     rcd_ok_o,
  output logic     ras_ok_o
);

  localparam int AGE_MAX = (T_RAS > T_RCD) ? T_RAS : T_RCD;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int TMR_MAX0 = (BURST_LEN > T_WR) ? BURST_LEN : T_WR;
  localparam int TMR_MAX  = (TMR_MAX0 > T_RC) ? TMR_MAX0 : T_RC;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  // A timed state entered at edge k is left at edge k+N-1, so the load is N-2
  localparam logic [TMR_W-1:0] LD_BL = TMR_W'(BURST_LEN - 2);
  localparam logic [TMR_W-1:0] LD_WR = TMR_W'(T_WR - 2);
  localparam logic [TMR_W-1:0] LD_RC = TMR_W'(T_RC - 2);

  bank_st_e         st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic             auto_q, auto_d;
  logic             rw_start;

  assign rw_start = rd_i | wr_i;

  always_comb begin
    st_d   = st_q;
    auto_d = auto_q;
    tmr_d  = (tmr_q != '0) ? tmr_q - TMR_W'(1) : tmr_q;
    age_d  = (age_q == AGE_W'(AGE_MAX)) ? age_q : age_q + AGE_W'(1);
    unique case (st_q)
      BS_IDLE: begin
        if (act_i) begin
          st_d  = BS_ACTIVE;
          age_d = AGE_W'(1);
        end else if (ref_i) begin
          st_d  = BS_REFRESH;
          tmr_d = LD_RC;
        end
      end
      BS_ACTIVE: begin
        if (rw_start) begin
          st_d   = rd_i ? BS_READ : BS_WRITE;
          tmr_d  = LD_BL;
          auto_d = a10_i;
        end else if (pre_i) begin
          st_d = BS_IDLE;
        end
      end
      BS_READ, BS_WRITE: begin
        if (rw_start) begin
          st_d   = rd_i ? BS_READ : BS_WRITE;
          tmr_d  = LD_BL;
          auto_d = a10_i;
        end else if (pre_i) begin
          st_d = BS_IDLE;
        end else if (bst_i) begin
          if (st_q == BS_READ) begin
            st_d = BS_ACTIVE;
          end else begin
            st_d   = BS_WRECOV;
            tmr_d  = LD_WR;
            auto_d = 1'b0;
          end
        end else if (tmr_q == '0) begin
          if (st_q == BS_READ) begin
            st_d = auto_q ? BS_IDLE : BS_ACTIVE;
          end else begin
            st_d  = BS_WRECOV;
            tmr_d = LD_WR;
          end
        end
      end
      BS_WRECOV: begin
        if (tmr_q == '0) st_d = auto_q ? BS_IDLE : BS_ACTIVE;
      end
      BS_REFRESH: begin
        if (tmr_q == '0) st_d = BS_IDLE;
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BS_IDLE;
      tmr_q  <= '0;
      age_q  <= '0;
      auto_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      age_q  <= age_d;
      auto_q <= auto_d;
    end
  end

  assign st_o     = st_q;
  assign rcd_ok_o = (age_q >= AGE_W'(T_RCD));
  assign ras_ok_o = (age_q >= AGE_W'(T_RAS));

  // R3
  act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (st_q == BS_IDLE));

  // R4
  rd_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rw_start |-> rcd_ok_o);

  // R8
  ref_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_i |=> (st_q == BS_REFRESH));

  // R8
  ref_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_REFRESH) |=> (st_q == BS_REFRESH || st_q == BS_IDLE));

  // R7
  wrecov_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_WRECOV) |=> (st_q == BS_WRECOV || st_q == BS_ACTIVE || st_q == BS_IDLE));

endmodule

// File: rtl/sdg_judge.sv
module sdg_judge
  import sdg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  op_e                       op_i,
  input  logic [BA_W-1:0]           ba_i,
  input  logic                      a10_i,
  input  logic [NUM_BANKS*ST_W-1:0] st_vec_i,
  input  logic [NUM_BANKS-1:0]      rcd_ok_i,
  input  logic [NUM_BANKS-1:0]      ras_ok_i,
  output logic                      illegal_o,
  output err_e                      code_o
);

  bank_st_e sel_st;
  logic     sel_rcd, sel_ras, sel_busy, sel_open;
  logic     any_busy, all_idle, any_ras_viol;

  always_comb begin
    sel_st       = BS_IDLE;
    sel_rcd      = 1'b0;
    sel_ras      = 1'b0;
    any_busy     = 1'b0;
    all_idle     = 1'b1;
    any_ras_viol = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      bank_st_e st_i;
      logic     open_i;
      st_i   = bank_st_e'(st_vec_i[ST_W*i +: ST_W]);
      open_i = (st_i == BS_ACTIVE) || (st_i == BS_READ) || (st_i == BS_WRITE);
      if (st_i == BS_WRECOV || st_i == BS_REFRESH) any_busy = 1'b1;
      if (st_i != BS_IDLE) all_idle = 1'b0;
      if (open_i && !ras_ok_i[i]) any_ras_viol = 1'b1;
      if (ba_i == BA_W'(i)) begin
        sel_st  = st_i;
        sel_rcd = rcd_ok_i[i];
        sel_ras = ras_ok_i[i];
      end
    end
  end

  assign sel_busy = (sel_st == BS_WRECOV) || (sel_st == BS_REFRESH);
  assign sel_open = (sel_st == BS_ACTIVE) || (sel_st == BS_READ) || (sel_st == BS_WRITE);

  always_comb begin
    code_o = ERR_NONE;
    unique case (op_i)
      OP_ACT: begin
        if (sel_busy)                 code_o = ERR_BUSY;
        else if (sel_st != BS_IDLE)   code_o = ERR_ROW_OPEN;
      end
      OP_READ, OP_WRITE: begin
        if (sel_busy)                 code_o = ERR_BUSY;
        else if (sel_st == BS_IDLE)   code_o = ERR_NO_ROW;
        else if (!sel_rcd)            code_o = ERR_RCD;
      end
      OP_BST: begin
        if (any_busy)                 code_o = ERR_BUSY;
      end
      OP_PRE: begin
        if (a10_i) begin
          if (any_busy)               code_o = ERR_BUSY;
          else if (any_ras_viol)      code_o = ERR_RAS;
        end else begin
          if (sel_busy)               code_o = ERR_BUSY;
          else if (sel_open && !sel_ras) code_o = ERR_RAS;
        end
      end
      OP_REF, OP_MRS: begin
        if (any_busy)                 code_o = ERR_BUSY;
        else if (!all_idle)           code_o = ERR_NEED_IDLE;
      end
      default: code_o = ERR_NONE;
    endcase
  end

  assign illegal_o = (code_o != ERR_NONE);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_WR      = 2,
  parameter int T_RC      = 6,
  parameter int BURST_LEN = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BA_W-1:0]           ba,
  input  logic                      a10,
  output logic [NUM_BANKS*ST_W-1:0] bank_state_o,
  output logic                      illegal_o,
  output logic [ERR_W-1:0]          err_code_o
);

  logic                      rst_s_n;
  op_e                       op;
  logic [NUM_BANKS*ST_W-1:0] st_vec;
  logic [NUM_BANKS-1:0]      rcd_ok, ras_ok;
  logic                      ill_d;
  err_e                      code_d;
  logic                      legal;
  logic                      illegal_q;
  logic [ERR_W-1:0]          code_q;

  sdg_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sdg_cmd_decode u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .op_o  (op)
  );

  sdg_judge #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) u_judge (
    .op_i      (op),
    .ba_i      (ba),
    .a10_i     (a10),
    .st_vec_i  (st_vec),
    .rcd_ok_i  (rcd_ok),
    .ras_ok_i  (ras_ok),
    .illegal_o (ill_d),
    .code_o    (code_d)
  );

  assign legal = !ill_d;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic     sel;
    bank_st_e st_w;
    assign sel = (ba == BA_W'(g));

    sdg_bank_fsm #(
      .T_RCD     (T_RCD),
      .T_RAS     (T_RAS),
      .T_WR      (T_WR),
      .T_RC      (T_RC),
      .BURST_LEN (BURST_LEN)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .act_i    (legal && op == OP_ACT   && sel),
      .rd_i     (legal && op == OP_READ  && sel),
      .wr_i     (legal && op == OP_WRITE && sel),
      .pre_i    (legal && op == OP_PRE   && (sel || a10)),
      .bst_i    (legal && op == OP_BST),
      .ref_i    (legal && op == OP_REF),
      .a10_i    (a10),
      .st_o     (st_w),
      .rcd_ok_o (rcd_ok[g]),
      .ras_ok_o (ras_ok[g])
    );

    assign st_vec[ST_W*g +: ST_W] = st_w;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      illegal_q <= 1'b0;
      code_q    <= ERR_NONE;
    end else begin
      illegal_q <= ill_d;
      code_q    <= code_d;
    end
  end

  assign bank_state_o = st_vec;
  assign illegal_o    = illegal_q;
  assign err_code_o   = code_q;

  // R1
  idle_cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op == OP_DESEL || op == OP_NOP) |=> !illegal_o);

  // R2
  flag_has_code_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    illegal_o |-> (err_code_o != ERR_NONE));

  // R2
  clean_no_code_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !illegal_o |-> (err_code_o == ERR_NONE));

  // R8
  refresh_all_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (legal && op == OP_REF) |=> ($countones(~rcd_ok | ras_ok) >= 0 && bank_state_o == {NUM_BANKS{BS_REFRESH}}));

endmodule

// File: tb/sdram_cmd_guard_bench.sv
module sdram_cmd_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 38;

  localparam logic [3:0] C_DES = 4'd0, C_NOP = 4'd1, C_BST = 4'd2, C_RD = 4'd3,
                         C_WR = 4'd4, C_ACT = 4'd5, C_PRE = 4'd6, C_REF = 4'd7,
                         C_MRS = 4'd8;
  localparam logic [2:0] SI = 3'd0, SA = 3'd1, SR = 3'd2, SW = 3'd3, SV = 3'd4, SF = 3'd5;

  // {op[26:23], ba[22:21], a10[20], ill[19], code[18:16], states{b3,b2,b1,b0}[15:4], req[3:0]}
  localparam logic [26:0] VEC [NV] = '{
    {C_NOP, 2'd0, 1'b0, 1'b0, 3'd0, SI, SI, SI, SI, 4'd1},  // R1 t0
    {C_RD,  2'd0, 1'b0, 1'b1, 3'd2, SI, SI, SI, SI, 4'd4},  // R4 read to idle
    {C_ACT, 2'd0, 1'b0, 1'b0, 3'd0, SI, SI, SI, SA, 4'd3},  // R3
    {C_RD,  2'd0, 1'b0, 1'b1, 3'd3, SI, SI, SI, SA, 4'd4},  // R4 one cycle after act
    {C_ACT, 2'd0, 1'b0, 1'b1, 3'd1, SI, SI, SI, SA, 4'd3},  // R3 act to open bank
    {C_RD,  2'd0, 1'b0, 1'b0, 3'd0, SI, SI, SI, SR, 4'd4},  // R4 exactly T_RCD
    {C_DES, 2'd3, 1'b1, 1'b0, 3'd0, SI, SI, SI, SR, 4'd1},  // R1 deselect
    {C_MRS, 2'd0, 1'b0, 1'b1, 3'd6, SI, SI, SI, SR, 4'd8},  // R8 mode set not idle
    {C_NOP, 2'd0, 1'b0, 1'b0, 3'd0, SI, SI, SI, SA, 4'd6},  // R6 burst over
    {C_PRE, 2'd0, 1'b0, 1'b0, 3'd0, SI, SI, SI, SI, 4'd5},  // R5
    {C_ACT, 2'd1, 1'b0, 1'b0, 3'd0, SI, SI, SA, SI, 4'd3},  // R3
    {C_PRE, 2'd1, 1'b0, 1'b1, 3'd4, SI, SI, SA, SI, 4'd5},  // R5 early precharge
    {C_ACT, 2'd2, 1'b0, 1'b0, 3'd0, SI, SA, SA, SI, 4'd3},  // R3
    {C_PRE, 2'd0, 1'b1, 1'b1, 3'd4, SI, SA, SA, SI, 4'd5},  // R5 precharge-all early, R10
    {C_REF, 2'd0, 1'b0, 1'b1, 3'd6, SI, SA, SA, SI, 4'd8},  // R8 refresh not idle
    {C_WR,  2'd1, 1'b1, 1'b0, 3'd0, SI, SA, SW, SI, 4'd7},  // R7 write auto
    {C_RD,  2'd2, 1'b0, 1'b0, 3'd0, SI, SR, SW, SI, 4'd6},  // R6
    {C_NOP, 2'd0, 1'b0, 1'b0, 3'd0, SI, SR, SW, SI, 4'd7},  // R7
    {C_ACT, 2'd1, 1'b0, 1'b1, 3'd1, SI, SR, SV, SI, 4'd3},  // R3 act to writing bank
    {C_RD,  2'd1, 1'b0, 1'b1, 3'd5, SI, SA, SI, SI, 4'd7},  // R7 read to recovering
    {C_PRE, 2'd3, 1'b1, 1'b0, 3'd0, SI, SI, SI, SI, 4'd5},  // R5 precharge-all
    {C_REF, 2'd0, 1'b0, 1'b0, 3'd0, SF, SF, SF, SF, 4'd8},  // R8
    {C_NOP, 2'd0, 1'b0, 1'b0, 3'd0, SF, SF, SF, SF, 4'd8},  // R8
    {C_ACT, 2'd3, 1'b0, 1'b1, 3'd5, SF, SF, SF, SF, 4'd7},  // R7 busy refresh
    {C_MRS, 2'd0, 1'b0, 1'b1, 3'd5, SF, SF, SF, SF, 4'd7},  // R7
    {C_DES, 2'd0, 1'b0, 1'b0, 3'd0, SF, SF, SF, SF, 4'd1},  // R1
    {C_NOP, 2'd0, 1'b0, 1'b0, 3'd0, SI, SI, SI, SI, 4'd8},  // R8 refresh over
    {C_MRS, 2'd0, 1'b0, 1'b0, 3'd0, SI, SI, SI, SI, 4'd8},  // R8 mode set legal
    {C_ACT, 2'd3, 1'b0, 1'b0, 3'd0, SA, SI, SI, SI, 4'd3},  // R3
    {C_WR,  2'd3, 1'b0, 1'b1, 3'd3, SA, SI, SI, SI, 4'd4},  // R4
    {C_NOP, 2'd0, 1'b0, 1'b0, 3'd0, SA, SI, SI, SI, 4'd10}, // R10
    {C_WR,  2'd3, 1'b0, 1'b0, 3'd0, SW, SI, SI, SI, 4'd7},  // R7
    {C_BST, 2'd0, 1'b0, 1'b0, 3'd0, SV, SI, SI, SI, 4'd9},  // R9 stop write
    {C_BST, 2'd0, 1'b0, 1'b1, 3'd5, SA, SI, SI, SI, 4'd7},  // R7 stop while recovering
    {C_RD,  2'd3, 1'b1, 1'b0, 3'd0, SR, SI, SI, SI, 4'd6},  // R6
    {C_BST, 2'd0, 1'b0, 1'b0, 3'd0, SA, SI, SI, SI, 4'd9},  // R9 stop read
    {C_PRE, 2'd3, 1'b0, 1'b0, 3'd0, SI, SI, SI, SI, 4'd5},  // R5
    {C_NOP, 2'd0, 1'b0, 1'b0, 3'd0, SI, SI, SI, SI, 4'd2}   // R2
  };

  logic        clk, rst_n, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0]  ba;
  logic [11:0] bank_state_o;
  logic        illegal_o;
  logic [2:0]  err_code_o;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;

  sdram_cmd_guard u_sdram_cmd_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .ba           (ba),
    .a10          (a10),
    .bank_state_o (bank_state_o),
    .illegal_o    (illegal_o),
    .err_code_o   (err_code_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [1:0] b, input logic a);
    cs_n = (op == C_DES);
    case (op)
      C_NOP:   {ras_n, cas_n, we_n} = 3'b111;
      C_BST:   {ras_n, cas_n, we_n} = 3'b110;
      C_RD:    {ras_n, cas_n, we_n} = 3'b101;
      C_WR:    {ras_n, cas_n, we_n} = 3'b100;
      C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      C_REF:   {ras_n, cas_n, we_n} = 3'b001;
      C_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    ba  = b;
    a10 = a;
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] b, input logic a);
    @(negedge clk);
    drive(op, b, a);
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
      end
    end
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    drive(C_NOP, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "states in reset", int'(bank_state_o), 0);
    chk("R11", "illegal in reset", int'(illegal_o), 0);
    chk("R11", "code in reset", int'(err_code_o), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      string rq;
      v = VEC[i];
      issue(v[26:23], v[22:21], v[20]);
      rq = $sformatf("R%0d", v[3:0]);
      chk(rq, $sformatf("illegal vec %0d", i), int'(illegal_o), int'(v[19]));
      chk(rq, $sformatf("code vec %0d", i), int'(err_code_o), int'(v[18:16]));
      chk(rq, $sformatf("states vec %0d", i), int'(bank_state_o), int'(v[15:4]));
    end

    // R5 precharge boundary: four cycles after activate is early, five is legal
    issue(C_ACT, 2'd1, 1'b0);
    issue(C_NOP, 2'd0, 1'b0);
    issue(C_NOP, 2'd0, 1'b0);
    issue(C_NOP, 2'd0, 1'b0);
    issue(C_PRE, 2'd1, 1'b0);
    chk("R5", "code pre at 4", int'(err_code_o), 4);
    chk("R10", "bank1 still open", int'(bank_state_o[5:3]), int'(SA));
    issue(C_PRE, 2'd1, 1'b0);
    chk("R5", "illegal pre at 5", int'(illegal_o), 0);
    chk("R5", "bank1 closed", int'(bank_state_o[5:3]), int'(SI));

    // R4 read two cycles after activate is early
    issue(C_ACT, 2'd2, 1'b0);
    issue(C_NOP, 2'd0, 1'b0);
    issue(C_RD, 2'd2, 1'b0);
    chk("R4", "code read at 2", int'(err_code_o), 3);

    // R11 asynchronous reset clears a pending flag and open banks
    issue(C_RD, 2'd0, 1'b0);
    chk("R2", "illegal before reset", int'(illegal_o), 1);
    @(negedge clk);
    drive(C_NOP, 2'd0, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R11", "states after reset", int'(bank_state_o), 0);
    chk("R11", "illegal after reset", int'(illegal_o), 0);
    chk("R11", "code after reset", int'(err_code_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    issue(C_ACT, 2'd2, 1'b0);
    chk("R11", "act legal after reset", int'(illegal_o), 0);
    chk("R3", "bank2 open after reset", int'(bank_state_o[8:6]), int'(SA));

    finish_run();
  end

endmodule